// File: doc/BRIEF.md
# Inter-processor mailbox register block

This block lets several processors exchange 32-bit messages through a shared register window. Six queues run independently. Each one is a small first-in first-out store: a bus write to the queue's message register adds a word, and a bus read of that register removes the oldest word. Each queue also has a full flag and an occupancy count that software can read.

Four interrupt ports serve the processors. Each port has a sticky event register and a mask register. Every queue owns two event bits: one for a newly accepted message and one for space freed in a full queue. Software clears an event by writing a one to its bit. A port's interrupt line is high whenever an event bit and the matching mask bit are both set. A fixed identification word, a read/write configuration word and a reset-done status word complete the map. Read data appears one clock after the read strobe.

Top module: `mailbox_regs`

## Requirements
- R1: After reset, all queues are empty, every event and mask register reads 0, the configuration word reads 0, all interrupt lines are low and the read data bus is 0.
- R2: Queue n (n = 0..5) has its message register at byte address 0x40+4n, its full flag at 0x80+4n and its occupancy count at 0xC0+4n. The queues are independent of each other.
- R3: A write to a message register appends the word to that queue, and reads return the words in the order they were written.
- R4: Each queue holds 4 words. A write to a full queue is discarded. The full flag reads 1 while the queue holds 4 words and 0 otherwise.
- R5: A read of an empty queue's message register returns 0 and changes no count, no event bit and no queue contents.
- R6: The occupancy register returns the number of words held, from 0 to 4.
- R7: Each accepted write to queue n sets bit 2n in the event register of all four ports, whatever the mask.
- R8: A read that takes queue n from 4 words to 3 sets bit 2n+1 in the event register of all four ports. Reads from a queue that is not full set no such bit.
- R9: Port u's event register is at 0x100+8u. Writing a 1 to a bit clears that bit, and writing 0 leaves it unchanged.
- R10: Port u's mask register is at 0x104+8u. It holds bits 11:0 and reads back with the upper bits 0. Interrupt line u is the OR of the bitwise AND of event register u and mask register u.
- R11: Address 0x00 returns the identification constant REV_ID, 0x10 is a 32-bit read/write configuration word, and 0x14 returns 1 (reset done).
- R12: Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.
- R13: Read data is registered. It shows the addressed value in the cycle after the read strobe, and is 0 after any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one access per cycle |
| busWrData | input | BUS_W | Write data |
| busRdEn | input | 1 | Read strobe; a read of a message register removes a word |
| busRdData | output | BUS_W | Registered read data |
| irqOut | output | NUM_USERS | One interrupt line per port |

## Verification
The assertions assume that each cycle carries at most one access, never a read and a write together. They also assume that the bus address is stable while a strobe is high. The bench drives every access through one-cycle tasks that raise exactly one strobe and then lower it, with an idle cycle between accesses. This keeps the stimulus inside those assumptions. The interrupt-mask property further relies on the mask register changing only through a bus write, so the bench never writes a mask register while expecting an event to raise its line in the same cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_Q     = 6;
  localparam int NUM_USERS = 4;
  localparam int EVT_W     = 2 * NUM_Q;
  localparam int IDX_W     = 3;

  localparam int REV_ADDR  = 'h000;
  localparam int CFG_ADDR  = 'h010;
  localparam int SYS_ADDR  = 'h014;
  localparam int MSG_BASE  = 'h040;
  localparam int FULL_BASE = 'h080;
  localparam int CNT_BASE  = 'h0C0;
  localparam int IRQ_BASE  = 'h100;
  localparam int MAP_END   = IRQ_BASE + 8 * NUM_USERS;

  typedef enum logic [3:0] {
    RD_NONE, RD_REV, RD_CFG, RD_SYS, RD_MSG, RD_FULL, RD_CNT, RD_IST, RD_IEN
  } rdKind_e;

  typedef struct packed {
    logic [NUM_Q-1:0]     push;
    logic [NUM_Q-1:0]     pop;
    logic [NUM_USERS-1:0] ackWr;
    logic [NUM_USERS-1:0] maskWr;
    logic                 cfgWr;
    rdKind_e              rdKind;
    logic [IDX_W-1:0]     rdIdx;
  } mbxStrobes_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int BUS_W = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             pushOk,
  output logic             popFull
);
  logic [BUS_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             popOk;

  assign full    = (count == CNT_W'(DEPTH));
  assign pushOk  = push & ~full;
  assign popOk   = pop & (count != '0);
  assign popFull = popOk & full;
  assign head    = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      if (pushOk && !popOk)      count <= count + 1'b1;
      else if (popOk && !pushOk) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output mbxStrobes_t       strobes
);
  logic [31:0] addrW;
  rdKind_e     kind;
  logic [IDX_W-1:0] idx;

  assign addrW = 32'(addr);

  always_comb begin
    strobes = '0;
    kind    = RD_NONE;
    idx     = '0;
    if (addrW == 32'(REV_ADDR)) kind = RD_REV;
    if (addrW == 32'(SYS_ADDR)) kind = RD_SYS;
    if (addrW == 32'(CFG_ADDR)) begin
      kind          = RD_CFG;
      strobes.cfgWr = wrEn;
    end
    for (int q = 0; q < NUM_Q; q++) begin
      if (addrW == 32'(MSG_BASE + 4 * q)) begin
        kind            = RD_MSG;
        idx             = IDX_W'(q);
        strobes.push[q] = wrEn;
        strobes.pop[q]  = rdEn;
      end
      if (addrW == 32'(FULL_BASE + 4 * q)) begin
        kind = RD_FULL;
        idx  = IDX_W'(q);
      end
      if (addrW == 32'(CNT_BASE + 4 * q)) begin
        kind = RD_CNT;
        idx  = IDX_W'(q);
      end
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (addrW == 32'(IRQ_BASE + 8 * u)) begin
        kind             = RD_IST;
        idx              = IDX_W'(u);
        strobes.ackWr[u] = wrEn;
      end
      if (addrW == 32'(IRQ_BASE + 8 * u + 4)) begin
        kind              = RD_IEN;
        idx               = IDX_W'(u);
        strobes.maskWr[u] = wrEn;
      end
    end
    strobes.rdKind = rdEn ? kind : RD_NONE;
    strobes.rdIdx  = idx;
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int          BUS_W  = 32,
  parameter int          DEPTH  = 4,
  parameter logic [31:0] REV_ID = 32'h0000_0031,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mbxStrobes_t          strobes,
  input  logic [BUS_W-1:0]     wrData,
  output logic [BUS_W-1:0]     rdData,
  output logic [NUM_USERS-1:0] irq
);
  logic [BUS_W-1:0] headW [NUM_Q];
  logic [CNT_W-1:0] cntW  [NUM_Q];
  logic [NUM_Q-1:0] fullW, pushOk, popFull;
  logic [EVT_W-1:0] evt;
  logic [EVT_W-1:0] stat [NUM_USERS];
  logic [EVT_W-1:0] mask [NUM_USERS];
  logic [BUS_W-1:0] cfgReg, rdValue;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    mbx_fifo #(.BUS_W(BUS_W), .DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rstN   (rstN),
      .push   (strobes.push[q]),
      .pop    (strobes.pop[q]),
      .wrData (wrData),
      .head   (headW[q]),
      .count  (cntW[q]),
      .full   (fullW[q]),
      .pushOk (pushOk[q]),
      .popFull(popFull[q])
    );
    assign evt[2*q]   = pushOk[q];
    assign evt[2*q+1] = popFull[q];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < NUM_USERS; u++) begin
        stat[u] <= '0;
        mask[u] <= '0;
      end
      cfgReg <= '0;
    end else begin
      for (int u = 0; u < NUM_USERS; u++) begin
        stat[u] <= (stat[u] & ~(strobes.ackWr[u] ? wrData[EVT_W-1:0] : '0)) | evt;
        if (strobes.maskWr[u]) mask[u] <= wrData[EVT_W-1:0];
      end
      if (strobes.cfgWr) cfgReg <= wrData;
    end
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_irq
    assign irq[u] = |(stat[u] & mask[u]);
  end

  always_comb begin
    rdValue = '0;
    unique case (strobes.rdKind)
      RD_REV: rdValue = BUS_W'(REV_ID);
      RD_CFG: rdValue = cfgReg;
      RD_SYS: rdValue = BUS_W'(1);
      RD_MSG: for (int q = 0; q < NUM_Q; q++)
                if (strobes.rdIdx == IDX_W'(q) && cntW[q] != '0) rdValue = headW[q];
      RD_FULL: for (int q = 0; q < NUM_Q; q++)
                 if (strobes.rdIdx == IDX_W'(q)) rdValue = BUS_W'(fullW[q]);
      RD_CNT: for (int q = 0; q < NUM_Q; q++)
                if (strobes.rdIdx == IDX_W'(q)) rdValue = BUS_W'(cntW[q]);
      RD_IST: for (int u = 0; u < NUM_USERS; u++)
                if (strobes.rdIdx == IDX_W'(u)) rdValue = BUS_W'(stat[u]);
      RD_IEN: for (int u = 0; u < NUM_USERS; u++)
                if (strobes.rdIdx == IDX_W'(u)) rdValue = BUS_W'(mask[u]);
      default: rdValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdValue;
  end
endmodule

// File: rtl/mailbox_regs.sv
module mailbox_regs
  import mbx_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          BUS_W  = 32,
  parameter int          DEPTH  = 4,
  parameter logic [31:0] REV_ID = 32'h0000_0031
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [BUS_W-1:0]     busWrData,
  input  logic                 busRdEn,
  output logic [BUS_W-1:0]     busRdData,
  output logic [NUM_USERS-1:0] irqOut
);
  mbxStrobes_t strobes;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr   (busAddr),
    .wrEn   (busWrEn),
    .rdEn   (busRdEn),
    .strobes(strobes)
  );

  mbx_datapath #(.BUS_W(BUS_W), .DEPTH(DEPTH), .REV_ID(REV_ID)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (busWrData),
    .rdData (busRdData),
    .irq    (irqOut)
  );
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
  import mbx_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          BUS_W  = 32,
  parameter int          DEPTH  = 4,
  parameter logic [31:0] REV_ID = 32'h0000_0031
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [BUS_W-1:0]     busWrData,
  input logic                 busRdEn,
  input logic [BUS_W-1:0]     busRdData,
  input logic [NUM_USERS-1:0] irqOut
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R13
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(busRdEn) |-> busRdData == '0);

  // R11
  sys_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(busRdEn && busAddr == ADDR_W'(SYS_ADDR)) |-> busRdData == BUS_W'(1));

  // R11
  rev_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(busRdEn && busAddr == ADDR_W'(REV_ADDR)) |-> busRdData == BUS_W'(REV_ID));

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(busRdEn && busAddr >= ADDR_W'(MAP_END)) |-> busRdData == '0);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(busRdEn && busAddr >= ADDR_W'(CNT_BASE)
                   && busAddr <= ADDR_W'(CNT_BASE + 4 * (NUM_Q - 1)))
    |-> busRdData <= BUS_W'(DEPTH));

  // R4
  full_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(busRdEn && busAddr >= ADDR_W'(FULL_BASE)
                   && busAddr <= ADDR_W'(FULL_BASE + 4 * (NUM_Q - 1)))
    |-> busRdData <= BUS_W'(1));

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_mask
    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
      armed && $past(busWrEn && !busRdEn && busAddr == ADDR_W'(IRQ_BASE + 8 * u + 4)
                     && busWrData[EVT_W-1:0] == '0) |-> !irqOut[u]);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> irqOut == '0);
endmodule

bind mailbox_regs mbx_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEPTH(DEPTH), .REV_ID(REV_ID)
) u_chk (.*);

// File: tb/mailbox_regs_bench.sv
module mailbox_regs_bench;
  localparam logic [31:0] REV = 32'h0000_0031;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [3:0]  irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [31:0] expData[$];
  string       expTag[$];

  always #4 clk = ~clk;

  mailbox_regs #(.ADDR_W(12), .BUS_W(32), .DEPTH(4), .REV_ID(REV)) u_mailbox_regs (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWrEn(wrEn), .busWrData(wrData),
    .busRdEn(rdEn), .busRdData(rdData), .irqOut(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; rdEn = 1'b1;
    expData.push_back(exp); expTag.push_back(tag);
    @(negedge clk); rdEn = 1'b0;
  endtask

  // monitor: compares each read result one cycle after the strobe
  initial forever begin
    @(posedge clk);
    if (rdEn) begin
      #2;
      if (expData.size() == 0) check(rdData, 32'hx, "unexpected read");
      else check(rdData, expData.pop_front(), expTag.pop_front());
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(32'(irq), 32'h0, "R1 irq after reset");
    check(rdData, 32'h0, "R1 read bus after reset");
    busRead(12'h000, REV, "R11 revision");
    busRead(12'h010, 32'h0, "R1 config reset");
    busRead(12'h014, 32'h1, "R11 reset done");
    for (int u = 0; u < 4; u++) begin
      busRead(12'(12'h100 + 8 * u), 32'h0, "R1 event reset");
      busRead(12'(12'h104 + 8 * u), 32'h0, "R1 mask reset");
    end
    for (int q = 0; q < 6; q++) busRead(12'(12'h0C0 + 4 * q), 32'h0, "R1 count reset");

    busWrite(12'h010, 32'hA5A5_0019);
    busRead(12'h010, 32'hA5A5_0019, "R11 config readback");
    busWrite(12'h018, 32'hFFFF_FFFF);
    busRead(12'h018, 32'h0, "R12 unmapped read");
    busRead(12'h010, 32'hA5A5_0019, "R12 config untouched");
    busRead(12'h120, 32'h0, "R12 beyond map");

    for (int q = 0; q < 6; q++) busWrite(12'(12'h040 + 4 * q), 32'hC0DE_0000 + 32'(q));
    for (int q = 0; q < 6; q++) busRead(12'(12'h0C0 + 4 * q), 32'h1, "R2 R6 one word each");
    for (int u = 0; u < 4; u++) busRead(12'(12'h100 + 8 * u), 32'h555, "R7 new-message bits");
    check(32'(irq), 32'h0, "R7 set without mask, no irq");
    for (int q = 5; q >= 0; q--) busRead(12'(12'h040 + 4 * q), 32'hC0DE_0000 + 32'(q), "R2 per-queue data");
    for (int u = 0; u < 4; u++) busWrite(12'(12'h100 + 8 * u), 32'hFFFF_FFFF);
    for (int u = 0; u < 4; u++) busRead(12'(12'h100 + 8 * u), 32'h0, "R9 clear all");

    for (int i = 0; i < 4; i++) busWrite(12'h044, 32'h1111_0000 + 32'(i));
    busWrite(12'h044, 32'hDEAD_BEEF);
    busRead(12'h084, 32'h1, "R4 full flag");
    busRead(12'h0C4, 32'h4, "R6 count at depth");
    busRead(12'h110, 32'h4, "R7 bit 2 for queue 1");
    busRead(12'h044, 32'h1111_0000, "R3 oldest first");
    busRead(12'h110, 32'hC, "R8 not-full bit");
    busRead(12'h084, 32'h0, "R4 not full");
    for (int i = 1; i < 4; i++) busRead(12'h044, 32'h1111_0000 + 32'(i), "R3 R4 order, drop");
    busRead(12'h044, 32'h0, "R5 empty read");
    busRead(12'h0C4, 32'h0, "R5 count stays 0");
    busRead(12'h110, 32'hC, "R5 R8 no new events");

    busWrite(12'h110, 32'h4);
    busRead(12'h110, 32'h8, "R9 write one clears");
    busWrite(12'h110, 32'h0);
    busRead(12'h110, 32'h8, "R9 write zero keeps");
    busRead(12'h118, 32'hC, "R9 other port kept");

    busWrite(12'h114, 32'h8);
    check(32'(irq), 32'h4, "R10 irq port 2");
    busRead(12'h114, 32'h8, "R10 mask readback");
    busWrite(12'h114, 32'hFFFF_F000);
    check(32'(irq), 32'h0, "R10 upper bits ignored");
    busRead(12'h114, 32'h0, "R10 mask width");
    busWrite(12'h11C, 32'h1);
    check(32'(irq), 32'h0, "R10 mask without event");
    busWrite(12'h040, 32'h0000_2222);
    check(32'(irq), 32'h8, "R7 R10 push raises irq 3");
    busWrite(12'h118, 32'h1);
    check(32'(irq), 32'h0, "R9 ack drops irq");
    busRead(12'h040, 32'h0000_2222, "R3 single word");

    busWrite(12'h041, 32'h5555_5555);
    check(rdData, 32'h0, "R13 zero after write cycle");
    busRead(12'h0C0, 32'h0, "R12 misaligned write ignored");
    busRead(12'h042, 32'h0, "R12 misaligned read");

    repeat (3) @(negedge clk);
    if (expData.size() != 0) check(32'(expData.size()), 32'h0, "R13 reads left unanswered");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule